// File: doc/BRIEF.md
# Miss-Triggered Core Sleep Sequencer

This block lives inside the L1 cache controller of one core. It decides when that core may be put to sleep while it waits on a long memory miss, and when it must be woken. The controller first reports a load that missed in L1. The sequencer records that address and waits for the last-level cache to report on it. If the last-level cache reports a hit, the sequencer returns to idle. If it reports a miss, the sequencer sends a one-cycle shutdown request to the core and waits for the checkpoint logic to finish saving state. It then holds the core asleep, but only once the pipeline has stalled.

When the fill data for the recorded address comes back, the sequencer sends a one-cycle wakeup request. It then waits for the restore to complete before it returns to idle. The fill can also arrive before the checkpoint has finished. In that case the sequencer lets the checkpoint complete, never enters the sleep state, and goes straight to restore. A counter of sleep entries can be read at any time. Miss reports that arrive while the sequencer is busy are dropped.

Top module: `miss_sleep_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `core_asleep`, `shutdown_o` and `wakeup_o` are 0 and `sleep_count` is 0.
- R2: In the cycle after a last-level report with `llc_rpt_miss`=1 for the tracked address, `shutdown_o` is 1 for exactly one cycle.
- R3: A last-level report with `llc_rpt_miss`=0 for the tracked address returns the block to idle without any shutdown.
- R4: A last-level report whose address differs from the tracked address has no effect.
- R5: `core_asleep` rises only once `ckpt_done` has been seen and `core_stalled` is 1. A finished checkpoint without a stall keeps the core awake.
- R6: While asleep, a fill for a different address has no effect. A fill for the tracked address raises `wakeup_o` for one cycle and clears `core_asleep`.
- R7: If a fill for the tracked address arrives during the checkpoint, `wakeup_o` pulses in the cycle after `ckpt_done`. In that case `core_asleep` never rises and `sleep_count` is unchanged.
- R8: After a wakeup, `busy` stays 1 until `rstr_done` is seen. The block is then idle.
- R9: An L1 miss report while `busy`=1 is ignored, and the address recorded earlier stays tracked.
- R10: `sleep_count` increases by one on each entry into sleep and wraps modulo 2^CNT_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l1_miss_vld | input | 1 | A load missed in L1 |
| l1_miss_addr | input | ADDR_W | Address of that load |
| llc_rpt_vld | input | 1 | Last-level cache report valid |
| llc_rpt_miss | input | 1 | 1 = miss in last level, 0 = hit |
| llc_rpt_addr | input | ADDR_W | Address the report refers to |
| fill_vld | input | 1 | Fill data returning |
| fill_addr | input | ADDR_W | Address of the fill |
| core_stalled | input | 1 | Core pipeline has stalled |
| ckpt_done | input | 1 | Checkpoint save complete |
| rstr_done | input | 1 | Checkpoint restore complete |
| shutdown_o | output | 1 | One-cycle shutdown request to the core |
| wakeup_o | output | 1 | One-cycle wakeup request to the core |
| core_asleep | output | 1 | Core held asleep |
| busy | output | 1 | Sequencer not idle |
| sleep_count | output | CNT_W | Count of sleep entries |

## Verification
The bench builds the block with ADDR_W=12 and CNT_W=3. The narrow counter wraps after eight sleeps, so a short run of repeated sleep cycles reaches the modulo behaviour of R10. Twelve-bit addresses are still wide enough to tell distinct tracked, foreign and late-miss addresses apart. The stall gate, the early fill and the busy-time drop are each driven as their own scenario.

// File: rtl/miss_sleep_seq.sv
module miss_sleep_seq #(
  parameter int ADDR_W = 40,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l1_miss_vld,
  input  logic [ADDR_W-1:0] l1_miss_addr,
  input  logic              llc_rpt_vld,
  input  logic              llc_rpt_miss,
  input  logic [ADDR_W-1:0] llc_rpt_addr,
  input  logic              fill_vld,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              core_stalled,
  input  logic              ckpt_done,
  input  logic              rstr_done,
  output logic              shutdown_o,
  output logic              wakeup_o,
  output logic              core_asleep,
  output logic              busy,
  output logic [CNT_W-1:0]  sleep_count
);

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_CKPT, S_SLEEP, S_RSTR} st_t;

  st_t              st, st_nx;
  logic [ADDR_W-1:0] trk;
  logic             ckpt_seen, fill_seen;

  wire rpt_hit  = llc_rpt_vld && (llc_rpt_addr == trk);
  wire fill_hit = fill_vld && (fill_addr == trk);
  wire ckpt_fin = ckpt_seen || ckpt_done;
  wire fill_any = fill_seen || fill_hit;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_IDLE:  if (l1_miss_vld) st_nx = S_PEND;
      S_PEND:  if (rpt_hit) st_nx = llc_rpt_miss ? S_CKPT : S_IDLE;
      S_CKPT:  if (ckpt_fin) begin
                 if (fill_any)          st_nx = S_RSTR;
                 else if (core_stalled) st_nx = S_SLEEP;
               end
      S_SLEEP: if (fill_hit) st_nx = S_RSTR;
      S_RSTR:  if (rstr_done) st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      trk         <= '0;
      ckpt_seen   <= 1'b0;
      fill_seen   <= 1'b0;
      shutdown_o  <= 1'b0;
      wakeup_o    <= 1'b0;
      sleep_count <= '0;
    end else begin
      st         <= st_nx;
      if (st == S_IDLE && l1_miss_vld) trk <= l1_miss_addr;
      ckpt_seen  <= (st == S_CKPT) && ckpt_fin;
      fill_seen  <= (st == S_CKPT) && fill_any;
      shutdown_o <= (st == S_PEND) && (st_nx == S_CKPT);
      wakeup_o   <= (st != S_RSTR) && (st_nx == S_RSTR);
      if (st != S_SLEEP && st_nx == S_SLEEP) sleep_count <= sleep_count + 1'b1;
    end
  end

  assign core_asleep = (st == S_SLEEP);
  assign busy        = (st != S_IDLE);

endmodule

module miss_sleep_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_stalled,
  input logic             shutdown_o,
  input logic             wakeup_o,
  input logic             core_asleep,
  input logic             busy,
  input logic [CNT_W-1:0] sleep_count
);

  p_shutdown_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_o |=> !shutdown_o);

  p_sleep_needs_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_asleep) |-> $past(core_stalled));

  p_wake_on_leave_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_asleep) |-> wakeup_o);

  p_wake_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup_o |=> !wakeup_o);

  p_idle_awake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !core_asleep);

  p_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_asleep) |-> sleep_count == CNT_W'($past(sleep_count) + 1'b1));

  p_count_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(core_asleep) |-> $stable(sleep_count));

  p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(shutdown_o && wakeup_o));

endmodule

bind miss_sleep_seq miss_sleep_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .core_stalled(core_stalled),
  .shutdown_o(shutdown_o), .wakeup_o(wakeup_o), .core_asleep(core_asleep),
  .busy(busy), .sleep_count(sleep_count));

// File: tb/miss_sleep_seq_tb.sv
`timescale 1ns/1ps
module miss_sleep_seq_tb_top;
  localparam int AW = 12;
  localparam int CW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic l1_miss_vld = 0, llc_rpt_vld = 0, llc_rpt_miss = 0, fill_vld = 0;
  logic [AW-1:0] l1_miss_addr = '0, llc_rpt_addr = '0, fill_addr = '0;
  logic core_stalled = 1, ckpt_done = 0, rstr_done = 0;
  logic shutdown_o, wakeup_o, core_asleep, busy;
  logic [CW-1:0] sleep_count;

  int total = 0, bad = 0;
  int exp_cnt = 0;

  always #2.5 clk = ~clk;

  miss_sleep_seq #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .l1_miss_vld(l1_miss_vld), .l1_miss_addr(l1_miss_addr),
    .llc_rpt_vld(llc_rpt_vld), .llc_rpt_miss(llc_rpt_miss), .llc_rpt_addr(llc_rpt_addr),
    .fill_vld(fill_vld), .fill_addr(fill_addr),
    .core_stalled(core_stalled), .ckpt_done(ckpt_done), .rstr_done(rstr_done),
    .shutdown_o(shutdown_o), .wakeup_o(wakeup_o), .core_asleep(core_asleep),
    .busy(busy), .sleep_count(sleep_count));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    l1_miss_vld = 0; llc_rpt_vld = 0; fill_vld = 0; ckpt_done = 0; rstr_done = 0;
  endtask

  task automatic l1_miss(input logic [AW-1:0] a);
    l1_miss_vld = 1; l1_miss_addr = a; tick();
  endtask

  task automatic rpt(input logic [AW-1:0] a, input logic m);
    llc_rpt_vld = 1; llc_rpt_addr = a; llc_rpt_miss = m; tick();
  endtask

  task automatic fill(input logic [AW-1:0] a);
    fill_vld = 1; fill_addr = a; tick();
  endtask

  task automatic restore_done(input string req);
    tick();
    chk({req, " busy in restore"}, busy, 1);
    rstr_done = 1; tick();
    chk({req, " idle after restore"}, busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 asleep", core_asleep, 0);
    chk("R1 shutdown", shutdown_o, 0);
    chk("R1 wakeup", wakeup_o, 0);
    chk("R1 count", sleep_count, 0);
  endtask

  task automatic t_full_sleep(input logic [AW-1:0] a);
    l1_miss(a);
    chk("R9 busy after miss", busy, 1);
    rpt(a, 1);
    chk("R2 shutdown pulse", shutdown_o, 1);
    tick();
    chk("R2 shutdown one cycle", shutdown_o, 0);
    core_stalled = 0; ckpt_done = 1; tick();
    chk("R5 awake without stall", core_asleep, 0);
    core_stalled = 1; tick();
    exp_cnt = (exp_cnt + 1) % (1 << CW);
    chk("R5 asleep after stall", core_asleep, 1);
    chk("R10 count", sleep_count, exp_cnt);
    fill(a ^ 12'h001);
    chk("R6 foreign fill keeps sleep", core_asleep, 1);
    chk("R6 foreign fill no wake", wakeup_o, 0);
    fill(a);
    chk("R6 wakeup pulse", wakeup_o, 1);
    chk("R6 asleep cleared", core_asleep, 0);
    restore_done("R8");
  endtask

  task automatic t_early_fill();
    l1_miss(12'h2B0);
    rpt(12'h2B0, 1);
    chk("R2 shutdown early case", shutdown_o, 1);
    fill(12'h2B0);
    chk("R7 no wake before ckpt", wakeup_o, 0);
    ckpt_done = 1; tick();
    chk("R7 wake after ckpt", wakeup_o, 1);
    chk("R7 never asleep", core_asleep, 0);
    chk("R7 count unchanged", sleep_count, exp_cnt);
    restore_done("R7");
  endtask

  task automatic t_llc_hit();
    l1_miss(12'h3C4);
    rpt(12'h3C4, 0);
    chk("R3 idle after hit", busy, 0);
    chk("R3 no shutdown", shutdown_o, 0);
  endtask

  task automatic t_foreign_rpt();
    l1_miss(12'h111);
    rpt(12'h222, 1);
    chk("R4 no shutdown", shutdown_o, 0);
    chk("R4 still busy", busy, 1);
    rpt(12'h111, 0);
    chk("R4 exit via own hit", busy, 0);
  endtask

  task automatic t_busy_drop();
    l1_miss(12'h444);
    l1_miss(12'h555);
    rpt(12'h555, 1);
    chk("R9 late miss not tracked", shutdown_o, 0);
    rpt(12'h444, 1);
    chk("R9 first miss tracked", shutdown_o, 1);
    core_stalled = 1; ckpt_done = 1; tick();
    exp_cnt = (exp_cnt + 1) % (1 << CW);
    chk("R9 asleep", core_asleep, 1);
    fill(12'h444);
    chk("R9 wake", wakeup_o, 1);
    restore_done("R9");
  endtask

  initial begin
    #(5.0 * 150000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_full_sleep(12'h0A0);
    t_early_fill();
    t_llc_hit();
    t_foreign_rpt();
    t_busy_drop();
    for (int i = 0; i < 8; i++) t_full_sleep(12'h100 + 12'(i));
    chk("R10 wrap value", sleep_count, exp_cnt);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule